// File: doc/BRIEF.md
# Rename Physical Register Free List

This block holds the physical registers that the renaming stage of an out-of-order core may hand out to new destinations. Integer and floating-point registers live in two separate pools. Both pools draw from one index space: the integer registers come first and the floating-point registers follow straight after them. Each pool is a circular first-in first-out buffer. An allocation therefore always returns the register of that class that was released earliest.

Each class has one allocate port, answered in the same cycle. Registers come back through three release ports. The generic port routes an index to a pool by its range and drops the two zero registers. The typed integer and typed floating-point ports push their index straight into the named pool. Each pool reports a not-empty flag and its occupancy.

A scoreboard keeps one free bit per physical index. It catches a release of a register that is already free and a grant of a register that is not marked free. Together with allocations against an empty pool, these raise error flags that stay set until reset. At reset, each pool holds, in ascending order, every register of its class that is not mapped to an architectural register.

Top module: `rfl_top`

## Requirements
- R1: After reset, the integer pool holds indices INT_ARCH..INT_REGS-1 and the floating-point pool holds INT_REGS+FP_ARCH..INT_REGS+FP_REGS-1, in ascending order. Both counts equal their class size minus its mapped count, and all four error flags are low. With the defaults, the counts are 8 and 8, and the first grants are 8 and 24.
- R2: Within a pool, grants come out in the order the registers were released (first in, first out).
- R3: When a request meets a non-empty pool, the valid output is high in the same cycle and the index output carries the oldest entry. That entry leaves the pool at the next rising edge.
- R4: On the generic port, an index below INT_REGS goes to the integer pool and an index from INT_REGS up to INT_REGS+FP_REGS-1 goes to the floating-point pool. An index of INT_REGS+FP_REGS or above changes neither pool and sets no flag.
- R5: A generic release of ZERO_IDX (default 0) or of ZERO_IDX+INT_REGS (default 16) is dropped. Both counts stay unchanged and no flag is set.
- R6: The typed integer and typed floating-point ports push the given index into their own pool with no range check and no zero filter.
- R7: When a typed release and a generic release target the same pool in one cycle, only the typed index enters that pool and the generic index is dropped.
- R8: A request to an empty pool gives valid low and index 0. From the next cycle on, it sets that class's allocate error flag (intAllocErr or fpAllocErr).
- R9: When a pool is empty, a release and a request in the same cycle produce no grant. The released index stays in the pool, so the count becomes 1.
- R10: Releasing an index whose free bit is already set raises dblFreeErr from the next cycle on. The index is still pushed unless the pool is full.
- R11: Granting an index whose free bit is clear raises dblAllocErr from the next cycle on.
- R12: Each pool's count becomes the old count plus one per accepted push minus one per grant. A push into a pool already holding its full class size is dropped. The not-empty output is high exactly when the count is non-zero.
- R13: All four error flags stay set until reset, and reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intAllocReq | input | 1 | Request one integer register |
| intAllocValid | output | 1 | Integer grant this cycle |
| intAllocIdx | output | IDXW | Granted integer index (0 when no grant) |
| fpAllocReq | input | 1 | Request one floating-point register |
| fpAllocValid | output | 1 | Floating-point grant this cycle |
| fpAllocIdx | output | IDXW | Granted floating-point index (0 when no grant) |
| relValid | input | 1 | Generic release strobe |
| relIdx | input | IDXW | Generic release index, routed by range |
| intRelValid | input | 1 | Typed integer release strobe |
| intRelIdx | input | IDXW | Index pushed into the integer pool |
| fpRelValid | input | 1 | Typed floating-point release strobe |
| fpRelIdx | input | IDXW | Index pushed into the floating-point pool |
| intNotEmpty | output | 1 | Integer pool holds at least one entry |
| intCount | output | ICNTW | Integer pool occupancy |
| fpNotEmpty | output | 1 | Floating-point pool holds at least one entry |
| fpCount | output | FCNTW | Floating-point pool occupancy |
| intAllocErr | output | 1 | Sticky: integer request met an empty pool |
| fpAllocErr | output | 1 | Sticky: floating-point request met an empty pool |
| dblAllocErr | output | 1 | Sticky: a register was granted while not marked free |
| dblFreeErr | output | 1 | Sticky: a register was released while already free |

## Verification
Directed sequences cover the ordering and routing cases one at a time:
- Draining a pool after releases on mixed ports separates true first-in first-out order from any index-sorted order.
- Generic releases of the two zero indices, an index past the top and an index just inside the floating-point range separate the three routing outcomes.
- A typed release and a generic release to the same pool in one cycle reveal which port has priority.
- A release and a request to an empty pool in one cycle show whether a grant can bypass the buffer.
- A repeated release followed by two grants of the duplicated index sets off the double-free check and then the double-grant check.

A long run of seeded random grants and releases across all three release ports, with empty-pool requests on the way, is then compared cycle by cycle against a queue model in the bench. This shows whether counts, grant order and sticky flags stay consistent under interleaved traffic.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
  // Strobes from the control into the two pool datapaths.
  typedef struct packed {
    logic intPush;
    logic intPop;
    logic fpPush;
    logic fpPop;
  } poolStrobe_t;
endpackage

// File: rtl/rfl_pool.sv
module rfl_pool #(
  parameter int DEPTH = 16,
  parameter int ARCH  = 8,
  parameter int BASE  = 0,
  parameter int IDXW  = 6,
  localparam int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW  = $clog2(DEPTH) + 1,
  localparam int FREE0 = DEPTH - ARCH
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            push,
  input  logic [IDXW-1:0] pushIdx,
  input  logic            pop,
  output logic [IDXW-1:0] headIdx,
  output logic [CNTW-1:0] count
);
  logic [IDXW-1:0] slots [DEPTH];
  logic [PTRW-1:0] headPtr, tailPtr;
  logic [CNTW-1:0] cnt;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++)
        slots[i] <= (i < FREE0) ? IDXW'(BASE + ARCH + i) : '0;
      headPtr <= '0;
      tailPtr <= PTRW'(FREE0 % DEPTH);
      cnt     <= CNTW'(FREE0);
    end else begin
      if (push) begin
        slots[tailPtr] <= pushIdx;
        tailPtr        <= bump(tailPtr);
      end
      if (pop) headPtr <= bump(headPtr);
      cnt <= cnt + CNTW'(push) - CNTW'(pop);
    end
  end

  assign headIdx = slots[headPtr];
  assign count   = cnt;

  // R12: the control never pushes into a full buffer
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (32'(cnt) < DEPTH));
  // R8: the control never pops an empty buffer
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (cnt != '0));
  // R12: occupancy never exceeds the depth
  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    32'(cnt) <= DEPTH);
endmodule

// File: rtl/rfl_ctrl.sv
module rfl_ctrl
  import rfl_pkg::*;
#(
  parameter int INT_REGS = 16,
  parameter int FP_REGS  = 16,
  parameter int INT_ARCH = 8,
  parameter int FP_ARCH  = 8,
  parameter int ZERO_IDX = 0,
  parameter int IDXW     = 6,
  localparam int TOTAL = INT_REGS + FP_REGS,
  localparam int SBW   = 1 << IDXW,
  localparam int ICNTW = $clog2(INT_REGS) + 1,
  localparam int FCNTW = $clog2(FP_REGS) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intAllocReq,
  input  logic             fpAllocReq,
  input  logic             relValid,
  input  logic [IDXW-1:0]  relIdx,
  input  logic             intRelValid,
  input  logic [IDXW-1:0]  intRelIdx,
  input  logic             fpRelValid,
  input  logic [IDXW-1:0]  fpRelIdx,
  input  logic [ICNTW-1:0] intCount,
  input  logic [FCNTW-1:0] fpCount,
  input  logic [IDXW-1:0]  intHead,
  input  logic [IDXW-1:0]  fpHead,
  output poolStrobe_t      strobe,
  output logic [IDXW-1:0]  intPushIdx,
  output logic [IDXW-1:0]  fpPushIdx,
  output logic             intAllocValid,
  output logic [IDXW-1:0]  intAllocIdx,
  output logic             fpAllocValid,
  output logic [IDXW-1:0]  fpAllocIdx,
  output logic             intAllocErr,
  output logic             fpAllocErr,
  output logic             dblAllocErr,
  output logic             dblFreeErr
);
  function automatic logic [SBW-1:0] resetBits();
    logic [SBW-1:0] b = '0;
    for (int i = 0; i < SBW; i++)
      b[i] = ((i >= INT_ARCH) && (i < INT_REGS)) ||
             ((i >= INT_REGS + FP_ARCH) && (i < TOTAL));
    return b;
  endfunction

  logic [SBW-1:0] freeBits;
  logic genToInt, genToFp, intRelHit, fpRelHit;
  logic intFull, fpFull, intEmpty, fpEmpty;
  logic dblFreeNow, dblAllocNow;

  // Generic routing by range with zero filtering (R4, R5); typed ports win (R6, R7)
  always_comb begin
    genToInt = relValid && (relIdx < IDXW'(INT_REGS)) && (relIdx != IDXW'(ZERO_IDX));
    genToFp  = relValid && (relIdx >= IDXW'(INT_REGS)) && (relIdx < IDXW'(TOTAL)) &&
               (relIdx != IDXW'(ZERO_IDX + INT_REGS));
    intRelHit  = intRelValid || genToInt;
    fpRelHit   = fpRelValid || genToFp;
    intPushIdx = intRelValid ? intRelIdx : relIdx;
    fpPushIdx  = fpRelValid ? fpRelIdx : relIdx;
  end

  assign intFull  = (intCount == ICNTW'(INT_REGS));
  assign fpFull   = (fpCount == FCNTW'(FP_REGS));
  assign intEmpty = (intCount == '0);
  assign fpEmpty  = (fpCount == '0);

  always_comb begin
    strobe.intPush = intRelHit && !intFull;
    strobe.fpPush  = fpRelHit && !fpFull;
    strobe.intPop  = intAllocReq && !intEmpty;
    strobe.fpPop   = fpAllocReq && !fpEmpty;
  end

  assign intAllocValid = strobe.intPop;
  assign fpAllocValid  = strobe.fpPop;
  assign intAllocIdx   = strobe.intPop ? intHead : '0;
  assign fpAllocIdx    = strobe.fpPop ? fpHead : '0;

  assign dblFreeNow  = (intRelHit && freeBits[intPushIdx]) ||
                       (fpRelHit && freeBits[fpPushIdx]);
  assign dblAllocNow = (strobe.intPop && !freeBits[intHead]) ||
                       (strobe.fpPop && !freeBits[fpHead]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeBits    <= resetBits();
      intAllocErr <= 1'b0;
      fpAllocErr  <= 1'b0;
      dblAllocErr <= 1'b0;
      dblFreeErr  <= 1'b0;
    end else begin
      logic [SBW-1:0] nb;
      nb = freeBits;
      if (strobe.intPop) nb[intHead] = 1'b0;
      if (strobe.fpPop)  nb[fpHead]  = 1'b0;
      if (strobe.intPush) nb[intPushIdx] = 1'b1;
      if (strobe.fpPush)  nb[fpPushIdx]  = 1'b1;
      freeBits <= nb;
      if (intAllocReq && intEmpty) intAllocErr <= 1'b1;
      if (fpAllocReq && fpEmpty)   fpAllocErr  <= 1'b1;
      if (dblAllocNow) dblAllocErr <= 1'b1;
      if (dblFreeNow)  dblFreeErr  <= 1'b1;
    end
  end

  // R8: an empty integer pool yields no grant and raises the flag next cycle
  a_r8_empty_int_flag: assert property (@(posedge clk) disable iff (!rstN)
    (intAllocReq && intEmpty) |=> intAllocErr);
  a_r8_empty_fp_flag: assert property (@(posedge clk) disable iff (!rstN)
    (fpAllocReq && fpEmpty) |=> fpAllocErr);
  // R9: never a grant while the pool was empty at the edge
  a_r9_no_bypass: assert property (@(posedge clk) disable iff (!rstN)
    intEmpty |-> !intAllocValid);
  // R5: a generic zero index alone never reaches the integer pool
  a_r5_zero_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && relIdx == IDXW'(ZERO_IDX) && !intRelValid) |-> !strobe.intPush);
  // R13: sticky flags
  a_r13_sticky_free: assert property (@(posedge clk) disable iff (!rstN)
    dblFreeErr |=> dblFreeErr);
  a_r13_sticky_alloc: assert property (@(posedge clk) disable iff (!rstN)
    dblAllocErr |=> dblAllocErr);
endmodule

// File: rtl/rfl_top.sv
module rfl_top
  import rfl_pkg::*;
#(
  parameter int INT_REGS = 16,
  parameter int FP_REGS  = 16,
  parameter int INT_ARCH = 8,
  parameter int FP_ARCH  = 8,
  parameter int ZERO_IDX = 0,
  localparam int TOTAL = INT_REGS + FP_REGS,
  localparam int IDXW  = $clog2(TOTAL) + 1,
  localparam int ICNTW = $clog2(INT_REGS) + 1,
  localparam int FCNTW = $clog2(FP_REGS) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intAllocReq,
  output logic             intAllocValid,
  output logic [IDXW-1:0]  intAllocIdx,
  input  logic             fpAllocReq,
  output logic             fpAllocValid,
  output logic [IDXW-1:0]  fpAllocIdx,
  input  logic             relValid,
  input  logic [IDXW-1:0]  relIdx,
  input  logic             intRelValid,
  input  logic [IDXW-1:0]  intRelIdx,
  input  logic             fpRelValid,
  input  logic [IDXW-1:0]  fpRelIdx,
  output logic             intNotEmpty,
  output logic [ICNTW-1:0] intCount,
  output logic             fpNotEmpty,
  output logic [FCNTW-1:0] fpCount,
  output logic             intAllocErr,
  output logic             fpAllocErr,
  output logic             dblAllocErr,
  output logic             dblFreeErr
);
  poolStrobe_t     strobe;
  logic [IDXW-1:0] intPushIdx, fpPushIdx, intHead, fpHead;

  rfl_ctrl #(.INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .INT_ARCH(INT_ARCH),
             .FP_ARCH(FP_ARCH), .ZERO_IDX(ZERO_IDX), .IDXW(IDXW)) u_ctrl (
    .clk, .rstN, .intAllocReq, .fpAllocReq, .relValid, .relIdx,
    .intRelValid, .intRelIdx, .fpRelValid, .fpRelIdx,
    .intCount, .fpCount, .intHead, .fpHead,
    .strobe, .intPushIdx, .fpPushIdx,
    .intAllocValid, .intAllocIdx, .fpAllocValid, .fpAllocIdx,
    .intAllocErr, .fpAllocErr, .dblAllocErr, .dblFreeErr
  );

  rfl_pool #(.DEPTH(INT_REGS), .ARCH(INT_ARCH), .BASE(0), .IDXW(IDXW)) u_intPool (
    .clk, .rstN, .push(strobe.intPush), .pushIdx(intPushIdx), .pop(strobe.intPop),
    .headIdx(intHead), .count(intCount)
  );

  rfl_pool #(.DEPTH(FP_REGS), .ARCH(FP_ARCH), .BASE(INT_REGS), .IDXW(IDXW)) u_fpPool (
    .clk, .rstN, .push(strobe.fpPush), .pushIdx(fpPushIdx), .pop(strobe.fpPop),
    .headIdx(fpHead), .count(fpCount)
  );

  assign intNotEmpty = (intCount != '0);
  assign fpNotEmpty  = (fpCount != '0);

  // R12: not-empty agrees with the pool occupancy
  a_r12_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    intAllocValid |-> intNotEmpty);
endmodule

// File: tb/rfl_top_tb.sv
module rfl_top_tb;
  localparam int NI = 16, NF = 16, AI = 8, AF = 8, TOT = NI + NF, IW = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic intAllocReq = 0, fpAllocReq = 0, relValid = 0, intRelValid = 0, fpRelValid = 0;
  logic [IW-1:0] relIdx = '0, intRelIdx = '0, fpRelIdx = '0;
  logic intAllocValid, fpAllocValid, intNotEmpty, fpNotEmpty;
  logic [IW-1:0] intAllocIdx, fpAllocIdx;
  logic [4:0] intCount, fpCount;
  logic intAllocErr, fpAllocErr, dblAllocErr, dblFreeErr;

  rfl_top u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int qI[$], qF[$];
  bit fb[64];
  bit eAI, eAF, eDA, eDF;
  int held[$];
  int lastIntIdx, lastFpIdx;
  bit lastIntV, lastFpV;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    qI.delete(); qF.delete();
    for (int i = AI; i < NI; i++) qI.push_back(i);
    for (int i = NI + AF; i < TOT; i++) qF.push_back(i);
    for (int i = 0; i < 64; i++) fb[i] = ((i >= AI && i < NI) || (i >= NI + AF && i < TOT));
    eAI = 0; eAF = 0; eDA = 0; eDF = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
    modelReset();
  endtask

  // Compare registered state with the model (R12, R13)
  task automatic checkState();
    chk(intCount, qI.size(), "R12 intCount");
    chk(fpCount, qF.size(), "R12 fpCount");
    chk(intNotEmpty, qI.size() != 0, "R12 intNotEmpty");
    chk(fpNotEmpty, qF.size() != 0, "R12 fpNotEmpty");
    chk(intAllocErr, eAI, "R13 intAllocErr");
    chk(fpAllocErr, eAF, "R13 fpAllocErr");
    chk(dblAllocErr, eDA, "R13 dblAllocErr");
    chk(dblFreeErr, eDF, "R13 dblFreeErr");
  endtask

  // One cycle: called at a negedge, returns at the next negedge
  task automatic doCycle(input bit ia, input bit fa, input bit gv, input int gi,
                         input bit iv, input int ii, input bit fv, input int fi);
    bit iHit, fHit, iPop, fPop, iPush, fPush;
    int iSel, fSel, hI, hF;
    checkState();
    intAllocReq = ia; fpAllocReq = fa;
    relValid = gv; relIdx = IW'(gi);
    intRelValid = iv; intRelIdx = IW'(ii);
    fpRelValid = fv; fpRelIdx = IW'(fi);
    #2;
    // R3: same-cycle grant of the oldest entry; R8/R9: none when empty
    iPop = ia && qI.size() > 0;
    fPop = fa && qF.size() > 0;
    hI = iPop ? qI[0] : 0;
    hF = fPop ? qF[0] : 0;
    chk(intAllocValid, iPop, "R3 intAllocValid");
    chk(intAllocIdx, hI, "R3 intAllocIdx");
    chk(fpAllocValid, fPop, "R3 fpAllocValid");
    chk(fpAllocIdx, hF, "R3 fpAllocIdx");
    lastIntV = intAllocValid; lastIntIdx = int'(intAllocIdx);
    lastFpV = fpAllocValid; lastFpIdx = int'(fpAllocIdx);
    // Routing per R4, R5, R6, R7
    iHit = iv || (gv && gi < NI && gi != 0);
    fHit = fv || (gv && gi >= NI && gi < TOT && gi != NI);
    iSel = iv ? ii : gi;
    fSel = fv ? fi : gi;
    iPush = iHit && qI.size() < NI;
    fPush = fHit && qF.size() < NF;
    if (ia && qI.size() == 0) eAI = 1;
    if (fa && qF.size() == 0) eAF = 1;
    if ((iPop && !fb[hI]) || (fPop && !fb[hF])) eDA = 1;
    if ((iHit && fb[iSel]) || (fHit && fb[fSel])) eDF = 1;
    @(posedge clk);
    if (iPop) begin void'(qI.pop_front()); fb[hI] = 0; end
    if (fPop) begin void'(qF.pop_front()); fb[hF] = 0; end
    if (iPush) begin qI.push_back(iSel); fb[iSel] = 1; end
    if (fPush) begin qF.push_back(fSel); fb[fSel] = 1; end
    @(negedge clk);
    intAllocReq = 0; fpAllocReq = 0; relValid = 0; intRelValid = 0; fpRelValid = 0;
  endtask

  task automatic idle();
    doCycle(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    doReset();
    // R1: reset contents and flags
    chk(intCount, 8, "R1 intCount at reset");
    chk(fpCount, 8, "R1 fpCount at reset");
    chk({intAllocErr, fpAllocErr, dblAllocErr, dblFreeErr}, 0, "R1 flags at reset");
    doCycle(1, 1, 0, 0, 0, 0, 0, 0);
    chk(lastIntIdx, 8, "R1 first integer grant");
    chk(lastFpIdx, 24, "R1 first fp grant");
    // R2: release 3 (typed) then 5 (generic); drain 9..15, then 3, then 5
    doCycle(0, 0, 0, 0, 1, 3, 0, 0);
    doCycle(0, 0, 1, 5, 0, 0, 0, 0);
    for (int k = 0; k < 7; k++) doCycle(1, 0, 0, 0, 0, 0, 0, 0);
    doCycle(1, 0, 0, 0, 0, 0, 0, 0);
    chk(lastIntIdx, 3, "R2 fifo order first");
    doCycle(1, 0, 0, 0, 0, 0, 0, 0);
    chk(lastIntIdx, 5, "R2 fifo order second");
    // R8: request on empty integer pool
    doCycle(1, 0, 0, 0, 0, 0, 0, 0);
    chk(lastIntV, 0, "R8 no grant when empty");
    chk(intAllocErr, 1, "R8 intAllocErr raised");
    // R9: release and request together on an empty pool
    doCycle(1, 0, 0, 0, 1, 9, 0, 0);
    chk(lastIntV, 0, "R9 no bypass grant");
    chk(intCount, 1, "R9 released index kept");
    doCycle(1, 0, 0, 0, 0, 0, 0, 0);
    chk(lastIntIdx, 9, "R9 kept index granted later");
    // R5: zero registers dropped on the generic port
    doCycle(0, 0, 1, 0, 0, 0, 0, 0);
    doCycle(0, 0, 1, 16, 0, 0, 0, 0);
    chk(intCount, 0, "R5 integer zero dropped");
    chk(fpCount, 7, "R5 fp zero dropped");
    // R4: out-of-range ignored, in-range fp routed
    doCycle(0, 0, 1, 40, 0, 0, 0, 0);
    chk(fpCount + intCount, 7, "R4 out-of-range ignored");
    doCycle(0, 0, 1, 20, 0, 0, 0, 0);
    chk(fpCount, 8, "R4 index 20 to fp pool");
    // R6: typed port accepts the zero register
    doCycle(0, 0, 0, 0, 1, 0, 0, 0);
    chk(intCount, 1, "R6 typed zero accepted");
    doCycle(1, 0, 0, 0, 0, 0, 0, 0);
    chk(lastIntIdx, 0, "R6 typed zero granted");
    // R7: typed wins over generic for the same pool
    doCycle(0, 0, 1, 2, 1, 6, 0, 0);
    chk(intCount, 1, "R7 only one push");
    doCycle(1, 0, 0, 0, 0, 0, 0, 0);
    chk(lastIntIdx, 6, "R7 typed index kept");
    // R10: double release; R11: double grant
    doCycle(0, 0, 0, 0, 1, 6, 0, 0);
    chk(dblFreeErr, 0, "R10 clean release");
    doCycle(0, 0, 0, 0, 1, 6, 0, 0);
    chk(dblFreeErr, 1, "R10 double release flagged");
    chk(intCount, 2, "R10 duplicate still pushed");
    doCycle(1, 0, 0, 0, 0, 0, 0, 0);
    chk(dblAllocErr, 0, "R11 first grant clean");
    doCycle(1, 0, 0, 0, 0, 0, 0, 0);
    chk(dblAllocErr, 1, "R11 double grant flagged");
    // R13: sticky until reset
    idle(); idle(); idle();
    chk(dblFreeErr && dblAllocErr && intAllocErr, 1, "R13 flags stay set");
    doReset();
    chk({intAllocErr, fpAllocErr, dblAllocErr, dblFreeErr}, 0, "R13 reset clears flags");

    // Random traffic against the model
    void'($urandom(32'd20240611));
    held.delete();
    for (int i = 1; i < AI; i++) held.push_back(i);
    for (int i = NI + 1; i < NI + AF; i++) held.push_back(i);
    for (int n = 0; n < 3000; n++) begin
      bit ia, fa, gv, iv, fv;
      int idx, pos, sel;
      ia = ($urandom % 3) == 0;
      fa = ($urandom % 3) == 0;
      gv = 0; iv = 0; fv = 0; idx = 0;
      if (held.size() > 0 && ($urandom % 2) == 0) begin
        pos = int'($urandom % held.size());
        idx = held[pos];
        held.delete(pos);
        sel = int'($urandom % 2);
        if (sel == 0) gv = 1;
        else if (idx < NI) iv = 1;
        else fv = 1;
      end
      doCycle(ia, fa, gv, idx, iv, idx, fv, idx);
      if (lastIntV) held.push_back(lastIntIdx);
      if (lastFpV) held.push_back(lastFpIdx);
    end
    checkState();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule